// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block gathers eight interrupt request lines, ranks them and hands the highest-ranked one to the processor as a byte vector. The host reaches it through a byte-wide bus with two addresses: a command address (`bus_sel` = 0) and a data address (`bus_sel` = 1). Before normal use the host loads a short chain of setup bytes. The first byte goes to the command address and says whether a cascade byte and an extra mode byte follow. The data address then takes the vector base, followed by whichever optional bytes the first byte asked for.

Once setup is complete, data writes load the mask and command writes carry operation commands. These commands either pick what a command-address read returns or retire in-service levels. A rising edge on a request line latches a request. The core raises `irq_pending` while any unmasked request is latched. An `ack_strobe` takes the lowest-numbered unmasked request, moves it from the request register to the in-service register, and one cycle later shows `vector base + line number` for a single cycle.

Top module: `pic_core`

## Requirements
- R1: After reset the request, in-service and mask registers are all zero, `irq_pending` is low, a command-address read returns the request register (0x00), and an acknowledge produces no `ack_valid`.
- R2: A command write with bit 4 set starts setup from any state, the ready state included. The next data write is taken as the vector base.
- R3: After the vector base is written, the sequencer moves on as follows. If setup-byte bit 1 is 0 (cascaded), it waits for a cascade byte. If bit 1 is 1 and bit 0 is 1, it waits for a mode byte. If both are otherwise, it enters the ready state.
- R4: After the cascade byte, the sequencer waits for a mode byte if setup-byte bit 0 is 1, and otherwise enters ready. A mode byte always leads to ready. None of these bytes changes the mask.
- R5: Only in the ready state does a data write load the mask register. A data-address read always returns the mask.
- R6: In the ready state, a command write with bits 4:3 = 01 loads a read select from bits 1:0. With select 10, command reads return the request register. With 11 they return the in-service register. With 00 or 01 they return 0x00. The select resets to 10.
- R7: A 0-to-1 transition on `irq_in[n]` sets request bit n. That bit stays set, even while the line stays high, until the request is acknowledged.
- R8: `irq_pending` is high exactly when some request bit is set whose mask bit is clear.
- R9: An `ack_strobe` with a pending request takes the lowest-numbered unmasked request n, sets in-service bit n and clears request bit n. On the next cycle `ack_valid` is high for one cycle, with `ack_vector` = vector base + n. With nothing pending, the strobe changes nothing.
- R10: In the ready state, a command write with bits 7:5 = 011 and bits 4:3 = 00 clears the in-service bit chosen by bits 2:0.
- R11: A command write with bits 7:5 = 001 and bits 4:3 = 00 clears only the lowest-numbered set in-service bit.
- R12: A command write with bits 4:3 = 00 and bit 7 set is ignored. Data writes made before setup has run leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_sel | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address (combinational) |
| irq_in | input | 8 | Edge-sensitive request lines |
| irq_pending | output | 1 | An unmasked request is latched |
| ack_strobe | input | 1 | Acknowledge request |
| ack_valid | output | 1 | Vector valid, one cycle |
| ack_vector | output | 8 | Vector base plus granted line |

## Verification
The bench walks every branch of the setup sequence. After each branch it checks whether a data byte lands in the mask: a sequencer that took the wrong branch would store a setup byte as the mask, or drop the mask write. It holds request lines high after they are acknowledged, which catches a level-sensitive latch that would re-request. It also acknowledges while every request is masked, to catch an acknowledge that fires on masked bits. The end-of-interrupt checks use two in-service bits at once and a rotate-style command that must be ignored. A non-specific clear that removed the wrong bit, or all bits, shows up in the in-service read-back.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    SQ_WAIT_SETUP = 3'd0,
    SQ_WAIT_BASE  = 3'd1,
    SQ_WAIT_CASC  = 3'd2,
    SQ_WAIT_MODE  = 3'd3,
    SQ_READY      = 3'd4
  } seq_e;

  localparam int SETUP_FLAG_BIT = 4;
  localparam int SU_MODE_BIT    = 0;
  localparam int SU_SOLO_BIT    = 1;
  localparam int CMD_EOI_BIT    = 5;
  localparam int CMD_LVL_BIT    = 6;
  localparam int CMD_ROT_BIT    = 7;
  localparam logic [1:0] RSEL_REQ  = 2'b10;
  localparam logic [1:0] RSEL_SERV = 2'b11;
endpackage

// File: rtl/pic_setup_seq.sv
module pic_setup_seq
  import pic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic         dat_wr,
  input  logic [W-1:0] wdata,
  output seq_e         state,
  output logic         setup_hit,
  output logic [W-1:0] vec_base
);
  seq_e         state_n;
  logic         solo_q, solo_n;
  logic         mode_q, mode_n;
  logic [W-1:0] base_n;
  logic         upd_en;

  assign setup_hit = cmd_wr & wdata[SETUP_FLAG_BIT];

  always_comb begin
    state_n = state;
    solo_n  = solo_q;
    mode_n  = mode_q;
    base_n  = vec_base;
    if (setup_hit) begin
      solo_n  = wdata[SU_SOLO_BIT];
      mode_n  = wdata[SU_MODE_BIT];
      state_n = SQ_WAIT_BASE;
    end else if (dat_wr) begin
      case (state)
        SQ_WAIT_BASE: begin
          base_n = wdata;
          if (!solo_q)     state_n = SQ_WAIT_CASC;
          else if (mode_q) state_n = SQ_WAIT_MODE;
          else             state_n = SQ_READY;
        end
        SQ_WAIT_CASC: state_n = mode_q ? SQ_WAIT_MODE : SQ_READY;
        SQ_WAIT_MODE: state_n = SQ_READY;
        default:      state_n = state;
      endcase
    end
  end

  assign upd_en = setup_hit | dat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_WAIT_SETUP;
      solo_q   <= 1'b0;
      mode_q   <= 1'b0;
      vec_base <= '0;
    end else if (upd_en) begin
      state    <= state_n;
      solo_q   <= solo_n;
      mode_q   <= mode_n;
      vec_base <= base_n;
    end
  end

  p_setup_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_hit |=> (state == SQ_WAIT_BASE));

  p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_READY && !setup_hit) |=> (state == SQ_READY));

  p_base_only_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_base != $past(vec_base)) |-> ($past(state) == SQ_WAIT_BASE));
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [W:0] seen;

  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < W; gi++) begin : g_rank
    assign grant[gi]  = vec[gi] & ~seen[gi];
    assign seen[gi+1] = seen[gi] | vec[gi];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign any = seen[W];
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] irq_in,
  input  logic [W-1:0] ack_set,
  input  logic [W-1:0] eoi_clr,
  output logic [W-1:0] irr,
  output logic [W-1:0] isr
);
  logic [W-1:0] line_q;
  logic [W-1:0] rise;
  logic [W-1:0] irr_n, isr_n;

  assign rise = irq_in & ~line_q;

  always_comb begin
    irr_n = (irr & ~ack_set) | rise;
    isr_n = (isr & ~eoi_clr) | ack_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      irr    <= '0;
      isr    <= '0;
    end else begin
      line_q <= irq_in;
      irr    <= irr_n;
      isr    <= isr_n;
    end
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irr) & ~$past(ack_set) & ~irr) == '0));

  p_ack_sets_serv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_set) |=> ((isr & $past(ack_set)) == $past(ack_set)));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_sel,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] irq_in,
  output logic         irq_pending,
  input  logic         ack_strobe,
  output logic         ack_valid,
  output logic [W-1:0] ack_vector
);
  localparam int IW = $clog2(W);

  seq_e          seq_state;
  logic          setup_hit;
  logic [W-1:0]  vec_base;
  logic          cmd_wr, dat_wr, ready;
  logic          op_cmd_wr, sel_cmd_wr;
  logic          eoi_spec, eoi_low;
  logic [W-1:0]  irr, isr, imr, imr_n;
  logic [1:0]    rsel, rsel_n;
  logic [W-1:0]  req_grant, serv_grant;
  logic [IW-1:0] req_idx, serv_idx;
  logic          req_any, serv_any;
  logic          ack_fire;
  logic [W-1:0]  ack_set, eoi_clr;
  logic [W-1:0]  vec_n;
  logic          imr_en, rsel_en;

  assign cmd_wr = bus_wr & ~bus_sel;
  assign dat_wr = bus_wr &  bus_sel;
  assign ready  = (seq_state == SQ_READY);

  pic_setup_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .dat_wr   (dat_wr),
    .wdata    (bus_wdata),
    .state    (seq_state),
    .setup_hit(setup_hit),
    .vec_base (vec_base)
  );

  assign op_cmd_wr  = cmd_wr & ready & (bus_wdata[4:3] == 2'b00);
  assign sel_cmd_wr = cmd_wr & ready & (bus_wdata[4:3] == 2'b01);
  assign eoi_spec   = op_cmd_wr & bus_wdata[CMD_EOI_BIT] & ~bus_wdata[CMD_ROT_BIT] &  bus_wdata[CMD_LVL_BIT];
  assign eoi_low    = op_cmd_wr & bus_wdata[CMD_EOI_BIT] & ~bus_wdata[CMD_ROT_BIT] & ~bus_wdata[CMD_LVL_BIT];

  pic_pick #(.W(W), .IW(IW)) u_req_pick (
    .vec  (irr & ~imr),
    .grant(req_grant),
    .idx  (req_idx),
    .any  (req_any)
  );

  pic_pick #(.W(W), .IW(IW)) u_serv_pick (
    .vec  (isr),
    .grant(serv_grant),
    .idx  (serv_idx),
    .any  (serv_any)
  );

  always_comb begin
    eoi_clr = '0;
    if (eoi_spec)                 eoi_clr[bus_wdata[IW-1:0]] = 1'b1;
    else if (eoi_low && serv_any) eoi_clr = serv_grant;
  end

  assign ack_fire = ack_strobe & req_any;
  assign ack_set  = ack_fire ? req_grant : '0;

  pic_req_bank #(.W(W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .ack_set(ack_set),
    .eoi_clr(eoi_clr),
    .irr    (irr),
    .isr    (isr)
  );

  assign imr_en  = dat_wr & ready;
  assign rsel_en = sel_cmd_wr;

  always_comb begin
    imr_n  = imr_en  ? bus_wdata      : imr;
    rsel_n = rsel_en ? bus_wdata[1:0] : rsel;
    vec_n  = vec_base + W'(req_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr  <= '0;
      rsel <= RSEL_REQ;
    end else begin
      imr  <= imr_n;
      rsel <= rsel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      ack_valid <= ack_fire;
      if (ack_fire) ack_vector <= vec_n;
    end
  end

  always_comb begin
    if (bus_sel)                 bus_rdata = imr;
    else if (rsel == RSEL_REQ)   bus_rdata = irr;
    else if (rsel == RSEL_SERV)  bus_rdata = isr;
    else                         bus_rdata = '0;
  end

  assign irq_pending = req_any;

  p_mask_ready_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imr != $past(imr)) |-> ($past(seq_state) == SQ_READY));

  p_ack_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($past(ack_strobe) && $past(irq_pending)));

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant) && ((|req_grant) == irq_pending));

  p_low_eoi_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_low && serv_any && !ack_fire) |=> ($countones(isr) == $countones($past(isr)) - 1));

  p_spec_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_spec && !ack_fire) |=> (isr[$past(bus_wdata[IW-1:0])] == 1'b0));
endmodule

// File: tb/sim_pic_core.sv
module sim_pic_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_sel, ack_strobe;
  logic [7:0] bus_wdata, irq_in;
  logic [7:0] bus_rdata, ack_vector;
  logic       irq_pending, ack_valid;
  int         nvec  = 0;
  int         nfail = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  pic_core #(.W(8)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_in     (irq_in),
    .irq_pending(irq_pending),
    .ack_strobe (ack_strobe),
    .ack_valid  (ack_valid),
    .ack_vector (ack_vector)
  );

  // {kind: 1=read-compare, sel, data, expected}
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h00, 8'h00}, {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h5A, 8'h00}, {1'b1, 1'b1, 8'h00, 8'h00},
    {1'b0, 1'b0, 8'h13, 8'h00}, {1'b0, 1'b1, 8'h40, 8'h00},
    {1'b0, 1'b1, 8'h77, 8'h00}, {1'b0, 1'b1, 8'h0F, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h0F}, {1'b0, 1'b0, 8'h12, 8'h00},
    {1'b0, 1'b1, 8'h20, 8'h00}, {1'b0, 1'b1, 8'hA5, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'hA5}, {1'b0, 1'b0, 8'h10, 8'h00},
    {1'b0, 1'b1, 8'h30, 8'h00}, {1'b0, 1'b1, 8'h04, 8'h00},
    {1'b0, 1'b1, 8'h3C, 8'h00}, {1'b1, 1'b1, 8'h00, 8'h3C},
    {1'b0, 1'b0, 8'h11, 8'h00}, {1'b0, 1'b1, 8'h50, 8'h00},
    {1'b0, 1'b1, 8'h01, 8'h00}, {1'b0, 1'b1, 8'h99, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h3C}, {1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:    return "R1";
      3:       return "R12";
      8:       return "R5";
      12:      return "R2";
      17:      return "R3";
      22:      return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string req);
    bus_sel = sel;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic exp_valid, input logic [7:0] exp_vec, input string req);
    @(negedge clk);
    ack_strobe = 1'b1;
    @(negedge clk);
    ack_strobe = 1'b0;
    check(req, {7'd0, ack_valid}, {7'd0, exp_valid});
    if (exp_valid) check(req, ack_vector, exp_vec);
    @(negedge clk);
    check(req, {7'd0, ack_valid}, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nvec++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h00;
    irq_in = 8'h00; ack_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", {7'd0, irq_pending}, 8'h00);

    // table walk: setup branches, mask loads, read-back
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) rd(VEC[i][16], VEC[i][7:0], vec_tag(i));
      else            wr(VEC[i][16], VEC[i][15:8]);
    end
    // vector base is now 0x50, mask 0x00, select = request register

    // R7 / R8: edges latch, mask gates pending
    set_req(8'h24);
    rd(1'b0, 8'h24, "R7");
    check("R8", {7'd0, irq_pending}, 8'h01);
    wr(1'b1, 8'h24);
    check("R8", {7'd0, irq_pending}, 8'h00);
    ack(1'b0, 8'h00, "R9");
    rd(1'b0, 8'h24, "R9");

    // R9: single unmasked request granted
    wr(1'b1, 8'h04);
    check("R8", {7'd0, irq_pending}, 8'h01);
    ack(1'b1, 8'h55, "R9");
    rd(1'b0, 8'h04, "R9");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h20, "R6");

    // R9: line 2 after unmask; R7: held-high lines do not re-request
    wr(1'b1, 8'h00);
    ack(1'b1, 8'h52, "R9");
    rd(1'b0, 8'h24, "R9");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R7");
    check("R7", {7'd0, irq_pending}, 8'h00);

    // R11 / R12 / R10: end-of-interrupt commands
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h20, "R11");
    wr(1'b0, 8'hA0);
    rd(1'b0, 8'h20, "R12");
    wr(1'b0, 8'h65);
    rd(1'b0, 8'h00, "R10");

    // R9: priority order, lowest first
    set_req(8'h00);
    set_req(8'h81);
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h81, "R7");
    ack(1'b1, 8'h50, "R9");
    ack(1'b1, 8'h57, "R9");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h81, "R9");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h80, "R11");
    wr(1'b0, 8'h63);
    rd(1'b0, 8'h80, "R10");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h00, "R6");

    // R1: reset mid-run clears everything
    set_req(8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b1, 8'h00, "R1");
    rd(1'b0, 8'h00, "R1");
    check("R1", {7'd0, irq_pending}, 8'h00);
    wr(1'b1, 8'h33);
    rd(1'b1, 8'h00, "R12");
    set_req(8'h02);
    ack(1'b1, 8'h01, "R1");

    finish_run();
  end
endmodule